// File: doc/BRIEF.md
# Multiplexed Seven-Segment Pattern Tester

This block drives a six-digit, time-multiplexed seven-segment display with a fixed self-test sequence. Only one digit is lit at a time. A scan counter steps the lit digit round-robin across the six positions at a refresh rate set by a parameter, so the whole display appears lit.

The content alternates between two test patterns, switching once per second. The one-second interval is counted from the system clock by a prescaler set by the clock frequency parameter. The first pattern shows 5,4,3,2,1,0 from the leftmost position to the rightmost. The second pattern shows 9,8,7,6 in the four rightmost positions, and the two leftmost positions are dark. The block is meant for checking a display board's wiring and segment mapping before any application logic feeds it real data.

Segment and digit-select polarity are parameters, so the block can drive common-anode or common-cathode boards directly. Both outputs are decoded combinationally from the internal state registers. They change in the same clock cycle as that state.

Top module: `seg_pattern_tester`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising clock edge, the block returns to the first pattern at scan position 0. Directly after reset, `dig_sel` selects position 0 and `seg` shows the digit 5.
- R2: With active-high digit polarity, exactly one bit of `dig_sel` is 1 at all times outside reset. Bit k of `dig_sel` selects position k, and position 0 is the leftmost digit.
- R3: The scan position holds for SCAN_DIV clock cycles and then advances by one. After position 5 it wraps back to position 0. After n rising edges since reset, the position is (n / SCAN_DIV) mod 6.
- R4: In the first pattern, position k shows the digit 5-k. The active-high segment codes use bit 0 = a through bit 6 = g: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F (hexadecimal).
- R5: In the second pattern, positions 2, 3, 4 and 5 show 9, 8, 7 and 6. Positions 0 and 1 are blanked, with every segment off (active-high code 00). Any non-decimal digit code decodes to this blank.
- R6: The pattern changes after every CLK_HZ clock cycles and alternates indefinitely. After n rising edges since reset, the second pattern is shown exactly when (n / CLK_HZ) is odd.
- R7: When SEG_ACT_HIGH is 0, `seg` is the bitwise inverse of the active-high code. When DIG_ACT_HIGH is 0, `dig_sel` is the bitwise inverse of the active-high one-hot select.
- R8: A reset applied in the middle of a run, in either pattern and at any scan position, restarts the sequence from the R1 state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| dig_sel | output | 6 | Digit select, one position lit at a time; bit 0 is the leftmost |
| seg | output | 7 | Segment drive, bit 0 = a through bit 6 = g |

## Verification
The bench builds the block with CLK_HZ set to 60 and SCAN_DIV set to 2. With these values a full scan takes 12 cycles, and each second of the display lasts exactly five scans. Several pattern changes, scan wraps and the boundary cycles on either side of them therefore fall within a few hundred cycles. A second instance with both polarity parameters cleared runs in lockstep with the first, so the inverted outputs can be compared cycle by cycle against the same expected codes.

// File: rtl/seg_pattern_tester.sv
module seg_pattern_tester #(
  parameter int CLK_HZ       = 50_000_000,
  parameter int SCAN_DIV     = 50_000,
  parameter bit SEG_ACT_HIGH = 1'b1,
  parameter bit DIG_ACT_HIGH = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  output logic [5:0] dig_sel,
  output logic [6:0] seg
);
  localparam int DIGITS = 6;
  localparam int SECW = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
  localparam int SCW  = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
  localparam logic [SECW-1:0] SEC_LAST  = SECW'(CLK_HZ - 1);
  localparam logic [SCW-1:0]  SCAN_LAST = SCW'(SCAN_DIV - 1);
  localparam logic [2:0]      POS_LAST  = 3'(DIGITS - 1);
  localparam logic [3:0]      BLANK     = 4'hF;

  logic [SECW-1:0] sec_cnt;
  logic [SCW-1:0]  scan_cnt;
  logic [2:0]      pos;
  logic            pat;
  logic            sec_tick, scan_tick;
  logic [3:0]      code;
  logic [6:0]      seg_raw;

  assign sec_tick  = (sec_cnt == SEC_LAST);
  assign scan_tick = (scan_cnt == SCAN_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_cnt  <= '0;
      scan_cnt <= '0;
      pos      <= '0;
      pat      <= 1'b0;
    end else begin
      sec_cnt  <= sec_tick ? '0 : sec_cnt + 1'b1;
      pat      <= pat ^ sec_tick;
      scan_cnt <= scan_tick ? '0 : scan_cnt + 1'b1;
      if (scan_tick)
        pos <= (pos == POS_LAST) ? 3'd0 : pos + 3'd1;
    end
  end

  always_comb begin
    if (!pat)
      code = {1'b0, 3'd5 - pos};
    else if (pos < 3'd2)
      code = BLANK;
    else
      code = 4'd11 - {1'b0, pos};
  end

  always_comb begin
    case (code)
      4'd0:    seg_raw = 7'h3F;
      4'd1:    seg_raw = 7'h06;
      4'd2:    seg_raw = 7'h5B;
      4'd3:    seg_raw = 7'h4F;
      4'd4:    seg_raw = 7'h66;
      4'd5:    seg_raw = 7'h6D;
      4'd6:    seg_raw = 7'h7D;
      4'd7:    seg_raw = 7'h07;
      4'd8:    seg_raw = 7'h7F;
      4'd9:    seg_raw = 7'h6F;
      default: seg_raw = 7'h00;
    endcase
  end

  assign dig_sel = (6'b000001 << pos) ^ {6{~DIG_ACT_HIGH}};
  assign seg     = seg_raw ^ {7{~SEG_ACT_HIGH}};
endmodule

// File: rtl/seg_pattern_tester_chk.sv
module seg_pattern_tester_chk #(
  parameter int CLK_HZ       = 50_000_000,
  parameter int SCAN_DIV     = 50_000,
  parameter bit SEG_ACT_HIGH = 1'b1,
  parameter bit DIG_ACT_HIGH = 1'b1,
  parameter int SECW         = 26,
  parameter int SCW          = 16
) (
  input logic            clk,
  input logic            rst,
  input logic [5:0]      dig_sel,
  input logic [6:0]      seg,
  input logic [2:0]      pos,
  input logic            pat,
  input logic [SECW-1:0] sec_cnt,
  input logic [SCW-1:0]  scan_cnt
);
  logic [5:0] dig_n;
  logic [6:0] seg_n;
  assign dig_n = DIG_ACT_HIGH ? dig_sel : ~dig_sel;
  assign seg_n = SEG_ACT_HIGH ? seg : ~seg;

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (dig_n == 6'b000001 && seg_n == 7'h6D));

  p_one_digit_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(dig_n) == 1);

  p_scan_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (int'(scan_cnt) != SCAN_DIV - 1) |=> $stable(dig_n));

  p_scan_step_r3: assert property (@(posedge clk) disable iff (rst)
    (int'(scan_cnt) == SCAN_DIV - 1) |=>
      dig_n == {$past(dig_n[4:0]), $past(dig_n[5])});

  p_blank_lead_r5: assert property (@(posedge clk) disable iff (rst)
    (pat && (dig_n[0] || dig_n[1])) |-> seg_n == 7'h00);

  p_pat_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (int'(sec_cnt) != CLK_HZ - 1) |=> $stable(pat));

  p_pat_flip_r6: assert property (@(posedge clk) disable iff (rst)
    (int'(sec_cnt) == CLK_HZ - 1) |=> pat != $past(pat));
endmodule

bind seg_pattern_tester seg_pattern_tester_chk #(
  .CLK_HZ(CLK_HZ), .SCAN_DIV(SCAN_DIV),
  .SEG_ACT_HIGH(SEG_ACT_HIGH), .DIG_ACT_HIGH(DIG_ACT_HIGH),
  .SECW(SECW), .SCW(SCW)
) chk_i (
  .clk(clk), .rst(rst), .dig_sel(dig_sel), .seg(seg),
  .pos(pos), .pat(pat), .sec_cnt(sec_cnt), .scan_cnt(scan_cnt)
);

// File: tb/seg_pattern_tester_tb.sv
module seg_pattern_tester_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CH = 60;
  localparam int SD = 2;
  localparam logic [6:0] EXP_SEG [12] = '{
    7'h6D, 7'h66, 7'h4F, 7'h5B, 7'h06, 7'h3F,
    7'h00, 7'h00, 7'h6F, 7'h7F, 7'h07, 7'h7D};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] dig_sel, dig_sel_inv;
  logic [6:0] seg, seg_inv;
  int n = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_pattern_tester #(.CLK_HZ(CH), .SCAN_DIV(SD)) dut_i (
    .clk(clk), .rst(rst), .dig_sel(dig_sel), .seg(seg));

  seg_pattern_tester #(.CLK_HZ(CH), .SCAN_DIV(SD),
                       .SEG_ACT_HIGH(1'b0), .DIG_ACT_HIGH(1'b0)) dut_inv_i (
    .clk(clk), .rst(rst), .dig_sel(dig_sel_inv), .seg(seg_inv));

  always @(posedge clk) n <= rst ? 0 : n + 1;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (n=%0d)", tag, act, exp, n);
    end
  endtask

  task automatic check_now();
    int p = (n / SD) % 6;
    int q = (n / CH) % 2;
    check(q ? "R5/R6 seg" : "R4/R6 seg", seg, EXP_SEG[q*6 + p]);
    check("R2/R3 dig_sel", dig_sel, 6'b000001 << p);
    check("R7 seg inverted", seg_inv, 7'(~EXP_SEG[q*6 + p]));
    check("R7 dig_sel inverted", dig_sel_inv, 6'(~(6'b000001 << p)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 dig_sel after reset", dig_sel, 6'b000001);
    check("R1 seg after reset", seg, 7'h6D);
    for (int i = 0; i < 5 * CH; i++) begin
      @(negedge clk);
      check_now();
    end
    // R8: reset mid-run inside second pattern, position 3
    while (!(((n / CH) % 2) == 1 && ((n / SD) % 6) == 3)) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R8 dig_sel after mid reset", dig_sel, 6'b000001);
    check("R8 seg after mid reset", seg, 7'h6D);
    rst = 1'b0;
    // R6 boundary: last cycle of first second, then first of the next
    while (n != CH - 1) begin
      @(negedge clk);
      check_now();
    end
    check("R6 last first-pattern cycle", seg, 7'h3F);
    @(negedge clk);
    check("R6 first second-pattern cycle", seg, 7'h00);
    check("R5 blank position 0", dig_sel, 6'b000001);
    for (int i = 0; i < 3 * CH; i++) begin
      @(negedge clk);
      check_now();
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule